// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Chain

This block is a wide synchronous up-counter assembled from identical four-bit counter stages. Each stage can be cleared at once, loaded from a parallel data word on a clock edge, advanced by one, or left unchanged. Every stage has two count enables. The "parallel" enable only gates counting. The "trickle" enable gates counting and also qualifies the stage's terminal-count flag, which is the signal used to chain the stages together.

A parameter selects how the stages are joined. In ripple wiring, each stage's terminal count feeds the trickle enable of the stage above it. In lookahead wiring, the trickle chain is kept, and the lowest stage's terminal count is also broadcast to the parallel enable of every higher stage. Both wirings give the same count sequence over the full width of 4×STAGES bits. The lowest stage sits in the low nibble of the data and count words. The chain's terminal-count output goes high when the whole word is all ones and the external trickle enable is high. It is typically used to enable a further counter or to mark the end of a division period.

Top module: `bin_chain_counter`

## Requirements
- R1: The count word advances modulo 2^(4×STAGES) and goes from all ones to all zeros on the next counting edge.
- R2: While `clr_n` is low, the count word is zero without waiting for a clock edge, and load and count requests are ignored.
- R3: With `clr_n` high and `load_n` low, the rising clock edge copies `din` into the count word, whatever the two enables are.
- R4: With `clr_n` and `load_n` high and both `cnt_en_par` and `cnt_en_trk` high, each rising edge adds exactly one to the whole count word.
- R5: With `load_n` high and either external enable low, the count word keeps its value across the edge.
- R6: `tc_out` is high exactly when the count word is all ones and `cnt_en_trk` is high. `cnt_en_par` has no effect on it.
- R7: Ripple wiring (MODE = CHAIN_RIPPLE) and lookahead wiring (MODE = CHAIN_LOOKAHEAD) produce identical count words and `tc_out` for the same stimulus.
- R8: Stage k holds bits [4k+3:4k]. A stage advances only on an edge where every lower stage is at 15 and counting is enabled, so for example 0x000F becomes 0x0010 and 0x0FFF becomes 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_par | input | 1 | External parallel count enable |
| cnt_en_trk | input | 1 | External trickle count enable, also qualifies `tc_out` |
| din | input | 4×STAGES | Parallel load data, lowest stage in the low nibble |
| q | output | 4×STAGES | Count word |
| tc_out | output | 1 | Chain terminal count |

## Verification
Three pairs of functions can fall in the same cycle: load and count, clear and load, and the wrap from all ones with the terminal-count flag. The bench provokes load and count together by driving `load_n` low while both enables are high. It expects the loaded data, not an increment. It provokes clear and load together by holding `clr_n` low across an edge with a load requested, and expects zero. It also checks that the count word drops to zero mid-cycle, before any edge arrives. For the wrap, it counts through all ones and expects `tc_out` high for exactly that cycle, and low when the trickle enable is withdrawn. Each result is judged on a ripple-wired and a lookahead-wired instance side by side.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int NIBBLE = 4;

  typedef enum logic {
    CHAIN_RIPPLE    = 1'b0,
    CHAIN_LOOKAHEAD = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  // clear > load > count > hold
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)                q <= '0;
    else if (!load_n)          q <= din;
    else if (en_par && en_trk) q <= q + 1'b1;
  end

  // only the trickle enable qualifies the flag
  assign tc = en_trk & (&q);
endmodule

// File: rtl/cnt_link.sv
module cnt_link
  import cnt_pkg::*;
#(
  parameter chain_mode_e MODE = CHAIN_RIPPLE
) (
  input  logic ext_par,
  input  logic prev_tc,
  input  logic head_tc,
  output logic par,
  output logic trk
);
  assign trk = prev_tc;

  generate
    if (MODE == CHAIN_LOOKAHEAD) begin : g_la
      // broadcast of lowest-stage carry, still held off by the external enable
      assign par = head_tc & ext_par;
    end else begin : g_rp
      logic unused_head;
      assign unused_head = head_tc;
      assign par = ext_par;
    end
  endgenerate
endmodule

// File: rtl/bin_chain_counter.sv
module bin_chain_counter
  import cnt_pkg::*;
#(
  parameter int          STAGES = 4,
  parameter chain_mode_e MODE   = CHAIN_RIPPLE
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       cnt_en_par,
  input  logic                       cnt_en_trk,
  input  logic [NIBBLE*STAGES-1:0]   din,
  output logic [NIBBLE*STAGES-1:0]   q,
  output logic                       tc_out
);
  localparam int WIDTH = NIBBLE * STAGES;

  logic head_tc;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_st
      logic par_w;
      logic trk_w;
      logic tc_w;

      if (i == 0) begin : g_head
        assign par_w = cnt_en_par;
        assign trk_w = cnt_en_trk;
      end else begin : g_tail
        cnt_link #(.MODE(MODE)) u_link (
          .ext_par (cnt_en_par),
          .prev_tc (g_st[i-1].tc_w),
          .head_tc (head_tc),
          .par     (par_w),
          .trk     (trk_w)
        );
      end

      cnt_stage #(.W(NIBBLE)) u_stage (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_par (par_w),
        .en_trk (trk_w),
        .din    (din[i*NIBBLE +: NIBBLE]),
        .q      (q[i*NIBBLE +: NIBBLE]),
        .tc     (tc_w)
      );
    end
  endgenerate

  assign head_tc = g_st[0].tc_w;
  assign tc_out  = g_st[STAGES-1].tc_w;

  logic unused_width;
  assign unused_width = (WIDTH == 0);
endmodule

// File: rtl/cnt_chain_checker.sv
module cnt_chain_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             cnt_en_par,
  input logic             cnt_en_trk,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             tc_out
);
  always @(negedge clk) begin
    if (clr_n === 1'b0) AST_CLEAR_ZERO: assert (q == '0); // R2
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en_par && cnt_en_trk) |=> q == $past(q) + 1'b1); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en_par && cnt_en_trk)) |=> $stable(q)); // R5

  AST_TC_FLAG: assert property (@(posedge clk) disable iff (!clr_n)
    tc_out == ((&q) && cnt_en_trk)); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en_par && tc_out) |=> q == '0); // R1
endmodule

bind bin_chain_counter cnt_chain_checker #(.WIDTH(cnt_pkg::NIBBLE*STAGES)) u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .load_n     (load_n),
  .cnt_en_par (cnt_en_par),
  .cnt_en_trk (cnt_en_trk),
  .din        (din),
  .q          (q),
  .tc_out     (tc_out)
);

// File: tb/tb_bin_chain_counter.sv
`timescale 1ns/1ps
module tb_bin_chain_counter;
  import cnt_pkg::*;

  localparam int STAGES = 4;
  localparam int W = 4 * STAGES;
  localparam int NVEC = 17;

  logic clk = 1'b0;
  logic clr_n, load_n, en_par, en_trk;
  logic [W-1:0] din;
  logic [W-1:0] q_rp, q_la;
  logic tc_rp, tc_la;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bin_chain_counter #(.STAGES(STAGES), .MODE(CHAIN_RIPPLE)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_par(en_par),
    .cnt_en_trk(en_trk), .din(din), .q(q_rp), .tc_out(tc_rp));

  bin_chain_counter #(.STAGES(STAGES), .MODE(CHAIN_LOOKAHEAD)) dut_la (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en_par(en_par),
    .cnt_en_trk(en_trk), .din(din), .q(q_la), .tc_out(tc_la));

  // {load_n, par, trk, din, expected q, expected tc}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 16'hFFFE, 16'hFFFE, 1'b0},  // R3 load, enables low
    {1'b1, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 1'b1},  // R4 R6
    {1'b1, 1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0},  // R1 wrap
    {1'b0, 1'b1, 1'b1, 16'h000E, 16'h000E, 1'b0},  // R3 load beats count
    {1'b1, 1'b1, 1'b1, 16'h0000, 16'h000F, 1'b0},
    {1'b1, 1'b1, 1'b1, 16'h0000, 16'h0010, 1'b0},  // R8
    {1'b1, 1'b0, 1'b1, 16'h0000, 16'h0010, 1'b0},  // R5 par low
    {1'b1, 1'b1, 1'b0, 16'h0000, 16'h0010, 1'b0},  // R5 trk low
    {1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1},  // R3 R6
    {1'b1, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 1'b1},  // R6 par no effect, R7 hold
    {1'b1, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 1'b0},  // R6 trk low
    {1'b1, 1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0},  // R1
    {1'b0, 1'b1, 1'b1, 16'h0FFF, 16'h0FFF, 1'b0},
    {1'b1, 1'b1, 1'b1, 16'h0000, 16'h1000, 1'b0},  // R8
    {1'b0, 1'b0, 1'b0, 16'h12EF, 16'h12EF, 1'b0},
    {1'b1, 1'b1, 1'b1, 16'h0000, 16'h12F0, 1'b0},  // R8
    {1'b1, 1'b0, 1'b0, 16'h0000, 16'h12F0, 1'b0}   // R5
  };

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_both(input string req, input logic [W-1:0] eq, input logic etc);
    check({req, " ripple q"}, q_rp, eq);
    check({req, " lookahead q"}, q_la, eq);
    check({req, " ripple tc"}, {{(W-1){1'b0}}, tc_rp}, {{(W-1){1'b0}}, etc});
    check({req, " lookahead tc"}, {{(W-1){1'b0}}, tc_la}, {{(W-1){1'b0}}, etc});
  endtask

  task automatic step(input logic ld, input logic p, input logic t, input logic [W-1:0] d);
    @(negedge clk);
    load_n = ld; en_par = p; en_trk = t; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] ref_q;
    logic [15:0] lfsr;
    clr_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    check_both("R2 reset state", '0, 1'b0);
    @(negedge clk);
    clr_n = 1'b1;

    // table walk, R1 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][35], VEC[k][34], VEC[k][33], VEC[k][32:17]);
      check_both($sformatf("R7 vector %0d", k), VEC[k][16:1], VEC[k][0]);
    end

    // R2: clear mid-cycle, no edge needed
    #1;
    clr_n = 1'b0;
    #0.5;
    check_both("R2 async clear", '0, 1'b0);
    // R2: clear overrides load on an edge
    step(1'b0, 1'b1, 1'b1, 16'hABCD);
    check_both("R2 clear beats load", '0, 1'b0);
    @(negedge clk);
    clr_n = 1'b1;
    step(1'b0, 1'b1, 1'b1, 16'hABCD);
    check_both("R3 load after clear", 16'hABCD, 1'b0);

    // R1 long wrap through all ones
    step(1'b0, 1'b0, 1'b0, 16'hFFF0);
    for (int k = 1; k <= 20; k++) begin
      step(1'b1, 1'b1, 1'b1, '0);
      if (k == 15) check_both("R6 tc at all ones", 16'hFFFF, 1'b1);
    end
    check_both("R1 wrapped count", 16'h0004, 1'b0);

    // R7 reference run with pseudo-random controls
    ref_q = 16'h0004;
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      logic ld, p, t;
      logic [W-1:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ld = (lfsr[3:0] != 4'h0);
      p  = lfsr[5] | lfsr[6];
      t  = lfsr[7] | lfsr[8] | lfsr[9];
      d  = lfsr[11] ? 16'hFFF8 : {lfsr[7:0], lfsr[15:8]};
      step(ld, p, t, d);
      if (!ld) ref_q = d;
      else if (p && t) ref_q = ref_q + 1'b1;
      check_both("R7 reference", ref_q, (&ref_q) && t);
    end

    finished = 1;
    finish_run();
  end
endmodule